// File: doc/BRIEF.md
# MSK Receive Frame-Detect Controller

This block sits behind the demodulator of an MSK modem. It handles the receive side. It takes a recovered bit clock and the demodulated bit stream. A CPU controls it through a small set of register fields: a three-bit operating mode, a raw-output select, a flag select and a frame-clear bit. All of its results come out on one shared status pin. Depending on the settings, that pin carries the raw data bits, a frame-detect indication or a byte-ready flag.

In frame mode the block hunts for a sync word in the incoming bits. When it finds the sync word, it drives the pin low for a fixed number of bit periods and sets the frame-clear bit by itself. It then packs the bits that follow into bytes. Each finished byte is placed in a receive buffer, and the CPU reads it at a fixed register address. When the CPU writes the frame-clear bit back to 0, the bit and byte paths are re-initialised and the block hunts again. There is no other way to restart frame detection.

Top module: `msk_rx_fdc`

## Requirements
- R1: Reception runs only when `mode_sel` is 3, 4 or 6. In modes 0, 1, 2, 5 and 7 the pin `rx_pin` is held high and every receive path is re-initialised.
- R2: With `raw_sel`=1 in an enabled mode, `rx_pin` takes the value of `bit_in` sampled on each falling edge of `bit_clk`, and holds it until the next falling edge.
- R3: With `raw_sel`=0, `flag_sel`=0 and `frame_clr`=0, `rx_pin` stays high while the block hunts. The hunt compares the last 16 bits received with the sync word (default 16'hB5C3). The oldest bit is in the MSB and the newest bit is in the LSB.
- R4: On the bit that completes the sync word, `frame_clr` becomes 1 and `rx_pin` goes low. The pin stays low for exactly FD_LEN bit clocks (default 8).
- R5: A CPU write of 0 to `frame_clr` is ignored while the frame-detect low period is active. The same write made after the period has ended clears the bit.
- R6: After a sync match, each group of 8 bits that follows is packed MSB first, so the first bit lands in bit 7. The finished byte is loaded into the buffer and marks it ready. With `flag_sel`=1 and the frame-detect period over, `rx_pin` is low while a byte is ready.
- R7: A read strobe at address 4'b0110 returns the buffered byte on `rd_data` and clears the ready state, so the flag pin goes back high. A read at any other address returns 0 and leaves the ready state unchanged.
- R8: If a byte completes while the previous one is still unread, the new byte overwrites the buffer and `overrun` is set. `overrun` then stays set.
- R9: Writing `frame_clr` from 1 to 0 after the frame-detect period does three things: it clears `overrun` and the ready state, and it restarts the sync hunt from an empty history.
- R10: The asynchronous active-low reset leaves `rx_pin` high, `frame_clr` at 0, `overrun` at 0 and the buffer empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Operating mode field |
| raw_sel | input | 1 | 1: pin carries raw demodulated bits |
| flag_sel | input | 1 | 1: pin carries the byte-ready flag |
| clr_wr | input | 1 | Write strobe for the frame-clear bit |
| clr_wdata | input | 1 | Value written to the frame-clear bit |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data (buffered byte at 4'b0110) |
| bit_clk | input | 1 | Recovered bit clock, sampled by clk |
| bit_in | input | 1 | Demodulated data bit |
| rx_pin | output | 1 | Shared status/data pin |
| frame_clr | output | 1 | Current value of the frame-clear bit |
| overrun | output | 1 | Sticky lost-byte indication |

## Verification
The properties assume that `bit_clk` and `bit_in` change only between clock edges. They also assume that each bit-clock phase lasts several system clocks, so that every falling edge produces exactly one sampling tick. The bench holds each bit-clock phase for four clocks and changes all inputs on the falling clock edge. The raw-follow property also assumes that the mode and raw select do not change in the cycle after a tick. The bench only changes those fields between bit periods.

// File: rtl/msk_rx_pkg.sv
package msk_rx_pkg;
   localparam logic [3:0] RXD_ADDR = 4'b0110;
   typedef logic [2:0] op_mode_t;

   function automatic logic mode_rx_on(input op_mode_t m);
      return (m == 3'd3) || (m == 3'd4) || (m == 3'd6);
   endfunction
endpackage

// File: rtl/msk_bclk_edge.sv
module msk_bclk_edge #(
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   output logic tick
);
   logic bclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_q <= !FALL_EDGE;
      else        bclk_q <= bclk;
   end

   generate
      if (FALL_EDGE) begin : g_fall
         assign tick = bclk_q & ~bclk;
      end else begin : g_rise
         assign tick = ~bclk_q & bclk;
      end
   endgenerate
endmodule

// File: rtl/msk_sync_hunt.sv
module msk_sync_hunt #(
   parameter int unsigned          SYNC_W    = 16,
   parameter logic [SYNC_W-1:0]    SYNC_WORD = '1,
   parameter int unsigned          FD_LEN    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reinit,
   input  logic hunt_en,
   input  logic tick,
   input  logic bit_in,
   output logic found,
   output logic fd_active
);
   localparam int unsigned FILL_W = $clog2(SYNC_W + 1);
   localparam int unsigned CNT_W  = $clog2(FD_LEN + 1);

   logic [SYNC_W-1:0] hist_q;
   logic [SYNC_W-1:0] hist_nxt;
   logic [FILL_W-1:0] fill_q;
   logic [CNT_W-1:0]  fd_cnt_q;

   assign hist_nxt  = {hist_q[SYNC_W-2:0], bit_in};
   assign found     = hunt_en && tick && (fill_q >= FILL_W'(SYNC_W - 1))
                      && (hist_nxt == SYNC_WORD);
   assign fd_active = (fd_cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q   <= '0;
         fill_q   <= '0;
         fd_cnt_q <= '0;
      end else if (reinit) begin
         hist_q   <= '0;
         fill_q   <= '0;
         fd_cnt_q <= '0;
      end else begin
         if (hunt_en && tick) begin
            hist_q <= hist_nxt;
            if (fill_q != FILL_W'(SYNC_W)) fill_q <= fill_q + 1'b1;
         end
         if (found)                        fd_cnt_q <= CNT_W'(FD_LEN);
         else if (tick && fd_cnt_q != '0)  fd_cnt_q <= fd_cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/msk_byte_pack.sv
module msk_byte_pack #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reinit,
   input  logic              pack_en,
   input  logic              tick,
   input  logic              bit_in,
   input  logic              rd_ack,
   output logic [DATA_W-1:0] byte_q,
   output logic              ready,
   output logic              overrun,
   output logic              byte_done
);
   localparam int unsigned BCNT_W = $clog2(DATA_W);

   logic [DATA_W-1:0] asm_q;
   logic [DATA_W-1:0] asm_nxt;
   logic [BCNT_W-1:0] cnt_q;

   assign asm_nxt   = {asm_q[DATA_W-2:0], bit_in};
   assign byte_done = pack_en && tick && (cnt_q == BCNT_W'(DATA_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asm_q   <= '0;
         cnt_q   <= '0;
         byte_q  <= '0;
         ready   <= 1'b0;
         overrun <= 1'b0;
      end else if (reinit) begin
         asm_q   <= '0;
         cnt_q   <= '0;
         byte_q  <= '0;
         ready   <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (pack_en && tick) begin
            asm_q <= asm_nxt;
            cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
         end
         if (byte_done) begin
            byte_q <= asm_nxt;
            ready  <= 1'b1;
            if (ready) overrun <= 1'b1;
         end else if (rd_ack) begin
            ready <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/msk_rx_fdc.sv
module msk_rx_fdc #(
   parameter int unsigned       SYNC_W    = 16,
   parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hB5C3,
   parameter int unsigned       FD_LEN    = 8,
   parameter int unsigned       DATA_W    = 8,
   parameter bit                BCLK_FALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_sel,
   input  logic              raw_sel,
   input  logic              flag_sel,
   input  logic              clr_wr,
   input  logic              clr_wdata,
   input  logic              rd_stb,
   input  logic [3:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              bit_clk,
   input  logic              bit_in,
   output logic              rx_pin,
   output logic              frame_clr,
   output logic              overrun
);
   import msk_rx_pkg::*;

   generate
      if (SYNC_W < 2)  begin : g_bad_sync  $error("SYNC_W must be at least 2");  end
      if (FD_LEN < 1)  begin : g_bad_fd    $error("FD_LEN must be at least 1");  end
      if (DATA_W < 2)  begin : g_bad_data  $error("DATA_W must be at least 2");  end
   endgenerate

   logic rx_en, bit_tick, found, fd_active, byte_ready, byte_done;
   logic clear_pulse, reinit, hunt_en, pack_en, rd_ack, raw_q, fclr_q;
   logic [DATA_W-1:0] byte_q;

   assign rx_en       = mode_rx_on(mode_sel);
   assign clear_pulse = clr_wr && !clr_wdata && fclr_q && !fd_active && !found;
   assign reinit      = !rx_en || raw_sel || clear_pulse;
   assign hunt_en     = rx_en && !raw_sel && !flag_sel && !fclr_q;
   assign pack_en     = rx_en && !raw_sel && fclr_q;
   assign rd_ack      = rd_stb && (rd_addr == RXD_ADDR);
   assign rd_data     = rd_ack ? byte_q : '0;
   assign frame_clr   = fclr_q;

   msk_bclk_edge #(.FALL_EDGE(BCLK_FALL)) edge_i (
      .clk(clk), .rst_n(rst_n), .bclk(bit_clk), .tick(bit_tick)
   );

   msk_sync_hunt #(.SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD), .FD_LEN(FD_LEN)) hunt_i (
      .clk(clk), .rst_n(rst_n), .reinit(reinit), .hunt_en(hunt_en),
      .tick(bit_tick), .bit_in(bit_in), .found(found), .fd_active(fd_active)
   );

   msk_byte_pack #(.DATA_W(DATA_W)) pack_i (
      .clk(clk), .rst_n(rst_n), .reinit(reinit), .pack_en(pack_en),
      .tick(bit_tick), .bit_in(bit_in), .rd_ack(rd_ack), .byte_q(byte_q),
      .ready(byte_ready), .overrun(overrun), .byte_done(byte_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fclr_q <= 1'b0;
         raw_q  <= 1'b1;
      end else begin
         if (found)                        fclr_q <= 1'b1;
         else if (clr_wr && clr_wdata)     fclr_q <= 1'b1;
         else if (clear_pulse)             fclr_q <= 1'b0;

         if (!rx_en || !raw_sel)           raw_q <= 1'b1;
         else if (bit_tick)                raw_q <= bit_in;
      end
   end

   always_comb begin
      if (!rx_en)         rx_pin = 1'b1;
      else if (raw_sel)   rx_pin = raw_q;
      else if (fd_active) rx_pin = 1'b0;
      else if (flag_sel)  rx_pin = !byte_ready;
      else                rx_pin = 1'b1;
   end
endmodule

// File: rtl/msk_rx_fdc_chk.sv
module msk_rx_fdc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_sel,
   input logic       raw_sel,
   input logic       bit_in,
   input logic       rx_pin,
   input logic       frame_clr,
   input logic       clr_wr,
   input logic       clr_wdata,
   input logic       rd_stb,
   input logic [3:0] rd_addr,
   input logic       overrun,
   input logic       fd_active,
   input logic       bit_tick,
   input logic       byte_done,
   input logic       byte_ready
);
   import msk_rx_pkg::*;

   AST_IDLE_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_rx_on(mode_sel) |-> rx_pin); // R1

   AST_RAW_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick && mode_rx_on(mode_sel) && raw_sel |=>
      (!mode_rx_on(mode_sel) || !raw_sel || rx_pin == $past(bit_in))); // R2

   AST_FD_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fd_active && mode_rx_on(mode_sel) && !raw_sel |-> !rx_pin); // R4

   AST_FD_SETS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fd_active) |-> frame_clr); // R4

   AST_CLR_WRITE0_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      fd_active && clr_wr && !clr_wdata |=> frame_clr); // R5

   AST_READ_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && rd_addr == RXD_ADDR && !byte_done |=> !byte_ready); // R7

   AST_OVERRUN_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready && byte_done && !(clr_wr && !clr_wdata) |=> overrun); // R8
endmodule

bind msk_rx_fdc msk_rx_fdc_chk chk_i (
   .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .raw_sel(raw_sel),
   .bit_in(bit_in), .rx_pin(rx_pin), .frame_clr(frame_clr), .clr_wr(clr_wr),
   .clr_wdata(clr_wdata), .rd_stb(rd_stb), .rd_addr(rd_addr), .overrun(overrun),
   .fd_active(fd_active), .bit_tick(bit_tick), .byte_done(byte_done),
   .byte_ready(byte_ready)
);

// File: tb/msk_rx_fdc_tb.sv
`timescale 1ns/1ps
module msk_rx_fdc_tb_top;
   localparam logic [15:0] SYNC = 16'hB5C3;
   localparam int          FDL  = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_sel = 3'd0;
   logic       raw_sel = 1'b0, flag_sel = 1'b0, clr_wr = 1'b0, clr_wdata = 1'b0;
   logic       rd_stb = 1'b0, bit_clk = 1'b0, bit_in = 1'b0;
   logic [3:0] rd_addr = 4'd0;
   logic [7:0] rd_data;
   logic       rx_pin, frame_clr, overrun;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   msk_rx_fdc dut_i (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .raw_sel(raw_sel),
      .flag_sel(flag_sel), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
      .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
      .bit_clk(bit_clk), .bit_in(bit_in), .rx_pin(rx_pin),
      .frame_clr(frame_clr), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); bit_in = b; bit_clk = 1'b1;
      repeat (4) @(negedge clk);
      bit_clk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic write_clr(input logic d);
      @(negedge clk); clr_wr = 1'b1; clr_wdata = d;
      @(negedge clk); clr_wr = 1'b0;
   endtask

   task automatic do_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); rd_stb = 1'b1; rd_addr = a;
      #1 d = rd_data;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   task automatic hunt_and_sync();
      for (int i = 0; i < 20; i++) send_bit(1'b0);
      for (int i = 15; i >= 1; i--) send_bit(SYNC[i]);
      chk(rx_pin == 1'b1, "R3 pin high before sync complete", rx_pin, 1);
      send_bit(SYNC[0]);
   endtask

   function automatic bit mode_on(input int m);
      return (m == 3) || (m == 4) || (m == 6);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(rx_pin == 1'b1, "R10 pin after reset", rx_pin, 1);
      chk(frame_clr == 1'b0, "R10 frame_clr after reset", frame_clr, 0);
      chk(overrun == 1'b0, "R10 overrun after reset", overrun, 0);
      rst_n = 1'b1;
      do_read(4'b0110, d);
      chk(d == 8'h00, "R10 buffer empty", d, 0);

      // R3 / R4 / R5: sync detect
      mode_sel = 3'd3;
      hunt_and_sync();
      chk(rx_pin == 1'b0, "R4 pin low on sync", rx_pin, 0);
      chk(frame_clr == 1'b1, "R4 frame_clr set by sync", frame_clr, 1);
      write_clr(1'b0);
      chk(frame_clr == 1'b1, "R5 write 0 ignored during FD", frame_clr, 1);
      flag_sel = 1'b1;
      for (int i = 7; i >= 1; i--) send_bit(~(i % 2 == 1));
      chk(rx_pin == 1'b0, "R4 pin still low before FD_LEN ticks", rx_pin, 0);
      send_bit(1'b0);
      // first byte: bits sent were 0,1,0,1,0,1,0 then 0 -> 8'b0101_0100
      chk(rx_pin == 1'b0, "R6 flag low on first byte", rx_pin, 0);
      do_read(4'b0110, d);
      chk(d == 8'h54, "R6 first byte MSB first", d, 8'h54);
      chk(rx_pin == 1'b1, "R7 flag high after read", rx_pin, 1);

      // R6 / R7 exhaustive byte sweep
      for (int v = 0; v < 256; v++) begin
         send_byte(8'(v));
         chk(rx_pin == 1'b0, "R6 flag low when byte ready", rx_pin, 0);
         do_read(4'b0110, d);
         chk(d == 8'(v), "R6 byte value", d, v);
         chk(rx_pin == 1'b1, "R7 flag released by read", rx_pin, 1);
      end
      chk(overrun == 1'b0, "R8 no overrun with timely reads", overrun, 0);

      // R7 wrong address
      send_byte(8'h9D);
      do_read(4'b0101, d);
      chk(d == 8'h00, "R7 other address reads zero", d, 0);
      chk(rx_pin == 1'b0, "R7 other address keeps flag", rx_pin, 0);
      do_read(4'b0110, d);
      chk(d == 8'h9D, "R7 read after wrong address", d, 8'h9D);

      // R8 overrun
      send_byte(8'h3C);
      send_byte(8'hC3);
      chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
      do_read(4'b0110, d);
      chk(d == 8'hC3, "R8 newest byte kept", d, 8'hC3);
      send_byte(8'h11);
      chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);

      // R9 clear and re-hunt
      write_clr(1'b0);
      chk(frame_clr == 1'b0, "R9 frame_clr cleared", frame_clr, 0);
      chk(overrun == 1'b0, "R9 overrun cleared", overrun, 0);
      chk(rx_pin == 1'b1, "R9 ready cleared", rx_pin, 1);
      flag_sel = 1'b0;
      hunt_and_sync();
      chk(rx_pin == 1'b0, "R9 second sync detected", rx_pin, 0);
      chk(frame_clr == 1'b1, "R9 frame_clr set again", frame_clr, 1);

      // R1 disable mid-frame
      @(negedge clk); mode_sel = 3'd5;
      @(negedge clk);
      chk(rx_pin == 1'b1, "R1 pin high when disabled", rx_pin, 1);

      // R1 / R2 raw sweep over all modes
      raw_sel = 1'b1;
      for (int m = 0; m < 8; m++) begin
         @(negedge clk); mode_sel = 3'(m);
         send_bit(1'b1);
         chk(rx_pin == 1'b1, "R2 raw one", rx_pin, 1);
         send_bit(1'b0);
         chk(rx_pin == (mode_on(m) ? 1'b0 : 1'b1), "R1 R2 raw zero by mode",
             rx_pin, mode_on(m) ? 0 : 1);
         @(negedge clk); bit_in = 1'b1;
         repeat (3) @(negedge clk);
         chk(rx_pin == (mode_on(m) ? 1'b0 : 1'b1), "R2 raw held between edges",
             rx_pin, mode_on(m) ? 0 : 1);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule